// File: doc/BRIEF.md
# NAND Page Program and Block Erase Sequencer

This block is the host-side engine that drives an 8-bit multiplexed NAND bus through a page program or a block erase, waits for the device to finish, and reports the outcome. A request names the operation, the row (page) address, the starting column, and for programs a byte count. The data bytes are pulled one at a time from a streaming input. The block generates the command, address and data write cycles on the control strobes. It then issues a status command and polls the status byte until the device reports ready.

All bus timing is counted in system clocks. Each minimum is given in nanoseconds and rounded up to whole cycles at the configured clock period. Completion is found by polling the ready bit of the status byte rather than by watching a ready/busy pin. The pass or fail result comes from the fail bit of the same byte. A timeout counter, sized past the slowest erase, ends a hung wait with an error.

Top module: `nand_pe_seq`

## Requirements
- R1: After reset and between operations, `ce_no`, `we_no` and `re_no` are high, `dq_oe_o`, `busy_o` and `done_o` are low.
- R2: A program sends command 80h (`cle_o`=1), then three address bytes (`ale_o`=1): the column, row bits 7:0, and row bits above 7 zero-extended. It then sends the data bytes (`cle_o`=`ale_o`=0) in stream order, and finally command 10h.
- R3: An erase sends command 60h, then two address bytes, then command D0h. The first address byte is row bits 7:0 with the low PG_W (default 4) page bits forced to zero, and the second is row bits above 7.
- R4: A program carries min(`len_i`, 528) data bytes, and `wdata_ack_o` pulses once for each data byte consumed. A count of 0 sends the header and 10h only.
- R5: Each write cycle holds `we_no` low at least WP_C cycles (3 at 10 ns) and high at least WH_C cycles (2), with a rise-to-rise period of at least 5 cycles. `dq_o`, `cle_o` and `ale_o` do not change while `we_no` is low.
- R6: After the confirm command's `we_no` rises, at least WB_C cycles (10) pass before the next `we_no` falls, and that next write is command 70h. `re_no` first falls at least WHR_C cycles (6) after the 70h write's `we_no` rises.
- R7: Status is read with `re_no` low for RL_C cycles (5) and sampled at the end of that low phase. Reads repeat until bit 6 of `dq_i` is 1, and no further read follows a ready status.
- R8: Completion gives a one-cycle `done_o`, with `error_o` equal to bit 0 of the ready status byte, and `error_o` holds until the next accepted start.
- R9: If ready is not seen within TMO_C cycles of the confirm write, the operation ends with `done_o` and `error_o`=1.
- R10: `busy_o` is high from the cycle after an accepted start until `done_o`. A `start_i` while busy is ignored.
- R11: `cle_o` and `ale_o` are never both high, `we_no` and `re_no` are never both low, and `ce_no` is low whenever either strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| start_i | input | 1 | request pulse, taken when idle |
| erase_i | input | 1 | 1 = block erase, 0 = page program |
| row_i | input | ROW_W | row (page) address |
| col_i | input | 8 | starting column for program |
| len_i | input | LEN_W | data byte count for program |
| wdata_i | input | 8 | current program data byte |
| wdata_ack_o | output | 1 | data byte taken at this clock edge |
| dq_i | input | 8 | bus data from device (status) |
| dq_o | output | 8 | bus data to device |
| dq_oe_o | output | 1 | bus output enable |
| cle_o | output | 1 | command latch enable |
| ale_o | output | 1 | address latch enable |
| ce_no | output | 1 | chip enable, active low |
| we_no | output | 1 | write strobe, active low |
| re_no | output | 1 | read strobe, active low |
| busy_o | output | 1 | operation in progress |
| done_o | output | 1 | one-cycle completion pulse |
| error_o | output | 1 | result of last operation: fail or timeout |

## Verification
The properties take for granted that the clock runs at the period given by CLK_NS, so that the cycle counts they check stand for the nanosecond minimums. They also take for granted that `wdata_i` is valid in every cycle `wdata_ack_o` is high and that `dq_i` holds the status byte steady while `re_no` is low. The bench's device model keeps within this. It presents the next payload byte combinationally from an index advanced on each acknowledge. It changes its status byte only on the clock edge, and it holds busy for a chosen number of cycles after seeing a confirm command, or forever for the timeout case.

// File: rtl/nand_pe_pkg.sv
package nand_pe_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CE, S_WLO, S_WHI, S_WB, S_WHR, S_RLO, S_RHI, S_DONE
  } seq_state_e;

  localparam logic [7:0] CMD_PROG_LOAD = 8'h80;
  localparam logic [7:0] CMD_PROG_GO   = 8'h10;
  localparam logic [7:0] CMD_ERASE_SET = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO  = 8'hD0;
  localparam logic [7:0] CMD_STATUS    = 8'h70;
  localparam int         ST_READY_BIT  = 6;
  localparam int         ST_FAIL_BIT   = 0;
  localparam int         HDR_PROG      = 4;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         exp_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign exp_o = (cnt_q == '0);
endmodule

// File: rtl/nand_busy_watch.sv
module nand_busy_watch #(
  parameter int LIMIT = 1000,
  localparam int W    = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic exp_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (clr_i)                          cnt_q <= '0;
    else if (en_i && cnt_q != W'(LIMIT))     cnt_q <= cnt_q + 1'b1;
  end

  assign exp_o = (cnt_q == W'(LIMIT));
endmodule

// File: rtl/nand_byte_seq.sv
module nand_byte_seq
  import nand_pe_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int PG_W   = 4,
  parameter int LEN_W  = 10,
  parameter int STEP_W = 10
) (
  input  logic              erase_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [7:0]        col_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              cmd_o,
  output logic              addr_o,
  output logic              data_o,
  output logic              last_o,
  output logic [7:0]        val_o
);
  logic [7:0]        row_lo, row_hi, row_lo_blk;
  logic [STEP_W-1:0] conf_step;

  assign row_lo     = row_i[7:0];
  assign row_hi     = 8'(row_i >> 8);
  assign row_lo_blk = row_lo & ~8'((1 << PG_W) - 1);
  assign conf_step  = STEP_W'(HDR_PROG) + STEP_W'(len_i);

  always_comb begin
    cmd_o  = 1'b0;
    addr_o = 1'b0;
    data_o = 1'b0;
    last_o = 1'b0;
    val_o  = 8'h00;
    if (erase_i) begin
      if (step_i == STEP_W'(0)) begin
        cmd_o = 1'b1; val_o = CMD_ERASE_SET;
      end else if (step_i == STEP_W'(1)) begin
        addr_o = 1'b1; val_o = row_lo_blk;
      end else if (step_i == STEP_W'(2)) begin
        addr_o = 1'b1; val_o = row_hi;
      end else begin
        cmd_o = 1'b1; last_o = 1'b1; val_o = CMD_ERASE_GO;
      end
    end else begin
      if (step_i == STEP_W'(0)) begin
        cmd_o = 1'b1; val_o = CMD_PROG_LOAD;
      end else if (step_i == STEP_W'(1)) begin
        addr_o = 1'b1; val_o = col_i;
      end else if (step_i == STEP_W'(2)) begin
        addr_o = 1'b1; val_o = row_lo;
      end else if (step_i == STEP_W'(3)) begin
        addr_o = 1'b1; val_o = row_hi;
      end else if (step_i == conf_step) begin
        cmd_o = 1'b1; last_o = 1'b1; val_o = CMD_PROG_GO;
      end else begin
        data_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/nand_pe_seq.sv
module nand_pe_seq
  import nand_pe_pkg::*;
#(
  parameter int CLK_NS    = 10,
  parameter int ROW_W     = 13,
  parameter int PG_W      = 4,
  parameter int LEN_W     = 10,
  parameter int MAX_LEN   = 528,
  parameter int T_WP_NS   = 25,
  parameter int T_WH_NS   = 15,
  parameter int T_WC_NS   = 50,
  parameter int T_DS_NS   = 20,
  parameter int T_DH_NS   = 10,
  parameter int T_WB_NS   = 100,
  parameter int T_WHR_NS  = 60,
  parameter int T_REA_NS  = 35,
  parameter int T_RP_NS   = 30,
  parameter int T_REH_NS  = 15,
  parameter int T_RC_NS   = 50,
  parameter int T_TMO_NS  = 12_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             erase_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [7:0]       col_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       wdata_i,
  output logic             wdata_ack_o,
  input  logic [7:0]       dq_i,
  output logic [7:0]       dq_o,
  output logic             dq_oe_o,
  output logic             cle_o,
  output logic             ale_o,
  output logic             ce_no,
  output logic             we_no,
  output logic             re_no,
  output logic             busy_o,
  output logic             done_o,
  output logic             error_o
);
  localparam int WP_C   = imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DS_NS, CLK_NS));
  localparam int WH_C   = imax(imax(ns2cyc(T_WH_NS, CLK_NS), ns2cyc(T_DH_NS, CLK_NS)),
                               imax(ns2cyc(T_WC_NS, CLK_NS) - WP_C, 1));
  localparam int WB_C   = imax(ns2cyc(T_WB_NS, CLK_NS), 1);
  localparam int WHR_C  = imax(ns2cyc(T_WHR_NS, CLK_NS), 1);
  localparam int RL_C   = imax(ns2cyc(T_REA_NS, CLK_NS) + 1, ns2cyc(T_RP_NS, CLK_NS));
  localparam int RH_C   = imax(ns2cyc(T_REH_NS, CLK_NS), imax(ns2cyc(T_RC_NS, CLK_NS) - RL_C, 1));
  localparam int TMO_C  = ns2cyc(T_TMO_NS, CLK_NS);
  localparam int TMAX   = imax(imax(WP_C, WH_C), imax(imax(WB_C, WHR_C), imax(RL_C, RH_C)));
  localparam int TW     = $clog2(TMAX + 1);
  localparam int STEP_W = $clog2(MAX_LEN + HDR_PROG + 1);

  seq_state_e        state_q, state_d;
  logic              erase_q;
  logic [ROW_W-1:0]  row_q;
  logic [7:0]        col_q, dq_q;
  logic [LEN_W-1:0]  len_q;
  logic [STEP_W-1:0] step_q, step_nx;
  logic              cle_q, ale_q, oe_q, last_q, stat_cmd_q, err_q;
  logic              st_ready_q, st_fail_q;
  logic              tmr_load, tmr_exp, tmo_exp, load_byte;
  logic [TW-1:0]     tmr_val;
  logic              sq_cmd, sq_addr, sq_data, sq_last;
  logic [7:0]        sq_val;
  logic              unused_dq;

  assign unused_dq = ^{dq_i[7], dq_i[5:1]};

  // next step index for the byte about to be placed on the bus
  assign step_nx = (state_q == S_CE) ? '0 : step_q + 1'b1;

  nand_byte_seq #(
    .ROW_W(ROW_W), .PG_W(PG_W), .LEN_W(LEN_W), .STEP_W(STEP_W)
  ) u_seq (
    .erase_i (erase_q),
    .step_i  (step_nx),
    .row_i   (row_q),
    .col_i   (col_q),
    .len_i   (len_q),
    .cmd_o   (sq_cmd),
    .addr_o  (sq_addr),
    .data_o  (sq_data),
    .last_o  (sq_last),
    .val_o   (sq_val)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (start_i) state_d = S_CE;
      S_CE:   state_d = S_WLO;
      S_WLO:  if (tmr_exp) state_d = stat_cmd_q ? S_WHR : S_WHI;
      S_WHI:  if (tmr_exp) state_d = last_q ? S_WB : S_WLO;
      S_WB:   if (tmr_exp) state_d = S_WLO;
      S_WHR:  if (tmr_exp) state_d = S_RLO;
      S_RLO:  if (tmr_exp) state_d = S_RHI;
      S_RHI:  if (tmr_exp) state_d = (st_ready_q || tmo_exp) ? S_DONE : S_RLO;
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_d)
      S_WLO:   tmr_val = TW'(WP_C - 1);
      S_WHI:   tmr_val = TW'(WH_C - 1);
      S_WB:    tmr_val = TW'(WB_C - 1);
      S_WHR:   tmr_val = TW'(WHR_C - 1);
      S_RLO:   tmr_val = TW'(RL_C - 1);
      S_RHI:   tmr_val = TW'(RH_C - 1);
      default: tmr_val = '0;
    endcase
  end

  assign tmr_load  = (state_d != state_q);
  assign load_byte = (state_q == S_CE) || (state_q == S_WHI && state_d == S_WLO);

  nand_phase_timer #(.W(TW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .exp_o  (tmr_exp)
  );

  nand_busy_watch #(.LIMIT(TMO_C)) u_watch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == S_WHI && state_d == S_WB),
    .en_i   (stat_cmd_q || state_q inside {S_WB, S_WHR, S_RLO, S_RHI}),
    .exp_o  (tmo_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      erase_q    <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
      len_q      <= '0;
      step_q     <= '0;
      dq_q       <= '0;
      cle_q      <= 1'b0;
      ale_q      <= 1'b0;
      oe_q       <= 1'b0;
      last_q     <= 1'b0;
      stat_cmd_q <= 1'b0;
      st_ready_q <= 1'b0;
      st_fail_q  <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && start_i) begin
        erase_q <= erase_i;
        row_q   <= row_i;
        col_q   <= col_i;
        len_q   <= (len_i > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : len_i;
        err_q   <= 1'b0;
      end
      if (load_byte) begin
        step_q <= step_nx;
        cle_q  <= sq_cmd;
        ale_q  <= sq_addr;
        oe_q   <= 1'b1;
        dq_q   <= sq_data ? wdata_i : sq_val;
        last_q <= sq_last;
      end
      if (state_q == S_WHI && state_d == S_WB) begin
        cle_q <= 1'b0;
        ale_q <= 1'b0;
        oe_q  <= 1'b0;
      end
      if (state_q == S_WB && state_d == S_WLO) begin
        cle_q      <= 1'b1;
        ale_q      <= 1'b0;
        oe_q       <= 1'b1;
        dq_q       <= CMD_STATUS;
        stat_cmd_q <= 1'b1;
        st_ready_q <= 1'b0;
      end
      if (state_q == S_WHR && state_d == S_RLO) begin
        cle_q <= 1'b0;
        oe_q  <= 1'b0;
      end
      if (state_q == S_RLO && state_d == S_RHI) begin
        st_ready_q <= dq_i[ST_READY_BIT];
        st_fail_q  <= dq_i[ST_FAIL_BIT];
      end
      if (state_d == S_DONE && state_q == S_RHI)
        err_q <= st_ready_q ? st_fail_q : 1'b1;
      if (state_q == S_DONE) stat_cmd_q <= 1'b0;
    end
  end

  assign wdata_ack_o = load_byte && sq_data;
  assign dq_o        = dq_q;
  assign dq_oe_o     = oe_q;
  assign cle_o       = cle_q;
  assign ale_o       = ale_q;
  assign ce_no       = (state_q == S_IDLE) || (state_q == S_DONE);
  assign we_no       = (state_q != S_WLO);
  assign re_no       = (state_q != S_RLO);
  assign busy_o      = !((state_q == S_IDLE) || (state_q == S_DONE));
  assign done_o      = (state_q == S_DONE);
  assign error_o     = err_q;
endmodule

// File: rtl/nand_pe_chk.sv
module nand_pe_chk #(
  parameter int WP_C = 3,
  parameter int WH_C = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cle_o,
  input logic       ale_o,
  input logic       ce_no,
  input logic       we_no,
  input logic       re_no,
  input logic [7:0] dq_o,
  input logic       dq_oe_o,
  input logic       busy_o,
  input logic       done_o
);
  logic [7:0] lo_cnt, hi_cnt;
  logic       wrote_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt  <= '0;
      hi_cnt  <= '0;
      wrote_q <= 1'b0;
    end else begin
      if (we_no) lo_cnt <= '0;
      else if (lo_cnt != 8'hFF) lo_cnt <= lo_cnt + 1'b1;
      if (!we_no) hi_cnt <= '0;
      else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 1'b1;
      if (ce_no) wrote_q <= 1'b0;
      else if (!we_no) wrote_q <= 1'b1;
    end
  end

  a_r5_we_low_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no) |-> (lo_cnt >= 8'(WP_C)));
  a_r5_we_high_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(we_no) && wrote_q) |-> (hi_cnt >= 8'(WH_C)));
  a_r5_bus_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no && $past(!we_no)) |-> ($stable(dq_o) && $stable(cle_o) && $stable(ale_o)));
  a_r5_oe_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> dq_oe_o);
  a_r7_no_drive_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_no |-> !dq_oe_o);
  a_r11_latch_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  a_r11_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !re_no));
  a_r11_ce_framing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no || !re_no) |-> !ce_no);
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_busy_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ce_no);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !done_o) |-> (ce_no && we_no && re_no && !dq_oe_o));
endmodule

bind nand_pe_seq nand_pe_chk #(.WP_C(WP_C), .WH_C(WH_C)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cle_o   (cle_o),
  .ale_o   (ale_o),
  .ce_no   (ce_no),
  .we_no   (we_no),
  .re_no   (re_no),
  .dq_o    (dq_o),
  .dq_oe_o (dq_oe_o),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/nand_pe_seq_test.sv
module nand_pe_seq_test;
  localparam int E_WP = 3, E_WH = 2, E_PER = 5, E_WB = 10, E_WHR = 6, E_RL = 5;
  localparam int E_TMO = 3000;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0, erase_i = 1'b0;
  logic [12:0] row_i = '0;
  logic [7:0]  col_i = '0;
  logic [9:0]  len_i = '0;
  logic [7:0]  wdata_i, dq_i, dq_o;
  logic        wdata_ack_o, dq_oe_o, cle_o, ale_o, ce_no, we_no, re_no;
  logic        busy_o, done_o, error_o;

  always #5 clk = ~clk;

  nand_pe_seq #(.T_TMO_NS(30_000)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .erase_i(erase_i),
    .row_i(row_i), .col_i(col_i), .len_i(len_i), .wdata_i(wdata_i),
    .wdata_ack_o(wdata_ack_o), .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
    .cle_o(cle_o), .ale_o(ale_o), .ce_no(ce_no), .we_no(we_no), .re_no(re_no),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // device model and bus monitor
  logic [7:0] pay [0:599];
  int  widx = 0;
  logic [7:0] cap_v [0:599];
  logic [1:0] cap_k [0:599];
  int  ncap = 0, busy_left = 0, busy_len = 0, rd_cnt = 0, cyc = 0;
  bit  fail_flag = 0, hang = 0;
  bit  we_q = 1, re_q = 1, wait_stat = 0, first_re = 0;
  int  lo_run = 0, hi_run = 0, min_lo = 999, min_hi = 999, min_per = 999, last_rise = -1000;
  int  re_run = 0, min_re = 999, conf_cyc = 0, stat_cyc = 0, wb_gap = 0, whr_gap = 0;
  logic ready;

  assign ready   = (busy_left == 0) && !hang;
  assign dq_i    = {1'b1, ready, 5'b0, ready & fail_flag};
  assign wdata_i = pay[widx % 600];

  always @(posedge clk) if (wdata_ack_o) widx <= widx + 1;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (busy_left > 0) busy_left = busy_left - 1;
    if (!we_no) begin
      if (we_q) begin
        if (hi_run > 0 && hi_run < min_hi) min_hi = hi_run;
        if (wait_stat) begin wb_gap = cyc - conf_cyc; wait_stat = 0; end
      end
      lo_run++;
    end else if (!we_q) begin
      if (lo_run < min_lo) min_lo = lo_run;
      if (cyc - last_rise < min_per) min_per = cyc - last_rise;
      last_rise = cyc;
      lo_run = 0;
      hi_run = 1;
      if (ncap < 600) begin cap_v[ncap] = dq_o; cap_k[ncap] = {cle_o, ale_o}; end
      ncap++;
      if (cle_o && (dq_o == 8'h10 || dq_o == 8'hD0)) begin
        busy_left = busy_len; conf_cyc = cyc; wait_stat = 1;
      end
      if (cle_o && dq_o == 8'h70) begin stat_cyc = cyc; first_re = 1; end
    end else hi_run++;
    if (!re_no) begin
      if (re_q) begin
        rd_cnt++;
        if (first_re) begin whr_gap = cyc - stat_cyc; first_re = 0; end
      end
      re_run++;
    end else begin
      if (!re_q && re_run < min_re) min_re = re_run;
      re_run = 0;
    end
    we_q = we_no;
    re_q = re_no;
  end

  // expected bus bytes
  logic [7:0] exp_v [0:599];
  logic [1:0] exp_k [0:599];
  int nexp;

  function automatic void build_exp(input bit er, input int row, input int col, input int len);
    int ln;
    ln = (len > 528) ? 528 : len;
    nexp = 0;
    if (er) begin
      exp_v[0] = 8'h60; exp_k[0] = 2'b10;
      exp_v[1] = 8'(row) & 8'hF0; exp_k[1] = 2'b01;
      exp_v[2] = 8'(row >> 8);    exp_k[2] = 2'b01;
      exp_v[3] = 8'hD0; exp_k[3] = 2'b10;
      nexp = 4;
    end else begin
      exp_v[0] = 8'h80; exp_k[0] = 2'b10;
      exp_v[1] = 8'(col); exp_k[1] = 2'b01;
      exp_v[2] = 8'(row); exp_k[2] = 2'b01;
      exp_v[3] = 8'(row >> 8); exp_k[3] = 2'b01;
      for (int i = 0; i < ln; i++) begin exp_v[4+i] = pay[i]; exp_k[4+i] = 2'b00; end
      exp_v[4+ln] = 8'h10; exp_k[4+ln] = 2'b10;
      nexp = 5 + ln;
    end
    exp_v[nexp] = 8'h70; exp_k[nexp] = 2'b10;
    nexp++;
  endfunction

  int op_err, op_done_cyc, op_len;

  task automatic run_op(input bit er, input int row, input int col, input int len,
                        input int bl, input bit fl, input bit hg, input bit poke);
    int t;
    for (int i = 0; i < 600; i++) pay[i] = 8'($urandom);
    build_exp(er, row, col, len);
    op_len = er ? 0 : ((len > 528) ? 528 : len);
    @(negedge clk);
    ncap = 0; widx = 0; rd_cnt = 0; busy_len = bl; fail_flag = fl; hang = hg;
    min_lo = 999; min_hi = 999; min_per = 999; min_re = 999; wb_gap = 0; whr_gap = 0;
    erase_i = er; row_i = 13'(row); col_i = 8'(col); len_i = 10'(len); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R10", "busy after start", busy_o, 1);
    t = 0;
    while (!done_o && t < 20000) begin
      @(negedge clk);
      t++;
      if (poke && t == 20) begin erase_i = ~er; row_i = 13'h1FFF; start_i = 1'b1; end
      if (poke && t == 21) start_i = 1'b0;
    end
    chk(done_o == 1'b1, "R8", "done seen", done_o, 1);
    op_err = error_o;
    op_done_cyc = cyc;
    @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R8", "done one cycle", done_o, 0);
    chk(error_o == op_err[0], "R8", "error held", error_o, op_err);
  endtask

  task automatic check_seq(input string req);
    int bad;
    bad = 0;
    chk(ncap == nexp, req, "bus write count", ncap, nexp);
    for (int i = 0; i < nexp && i < ncap; i++)
      if (cap_v[i] !== exp_v[i] || cap_k[i] !== exp_k[i]) bad++;
    chk(bad == 0, req, "bus bytes mismatched", bad, 0);
  endtask

  task automatic check_timing();
    chk(min_lo >= E_WP, "R5", "we low cycles", min_lo, E_WP);
    chk(min_hi >= E_WH, "R5", "we high cycles", min_hi, E_WH);
    chk(min_per >= E_PER, "R5", "write period", min_per, E_PER);
    chk(wb_gap >= E_WB, "R6", "confirm to status gap", wb_gap, E_WB);
    chk(whr_gap >= E_WHR, "R6", "status cmd to re gap", whr_gap, E_WHR);
    chk(min_re >= E_RL, "R7", "re low cycles", min_re, E_RL);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ce_no && we_no && re_no, "R1", "strobes high", {ce_no, we_no, re_no}, 7);
    chk(!busy_o && !done_o && !dq_oe_o, "R1", "idle outputs", {busy_o, done_o, dq_oe_o}, 0);

    // R2 directed program, pass, long busy
    run_op(0, 13'h1ABC, 8'h5A, 6, 300, 0, 0, 0);
    check_seq("R2");
    check_timing();
    chk(widx == op_len, "R4", "ack count", widx, op_len);
    chk(op_err == 0, "R8", "program pass", op_err, 0);
    chk(rd_cnt > 1, "R7", "polled repeatedly", rd_cnt, 2);

    // R8 program fail, instant ready: single read
    run_op(0, 13'h0042, 8'h00, 2, 0, 1, 0, 0);
    check_seq("R2");
    chk(op_err == 1, "R8", "program fail bit", op_err, 1);
    chk(rd_cnt == 1, "R7", "single read when ready", rd_cnt, 1);

    // R3 erase, page bits masked
    run_op(1, 13'h1FFF, 8'hAA, 9, 150, 0, 0, 0);
    check_seq("R3");
    check_timing();
    chk(widx == 0, "R4", "no ack on erase", widx, 0);
    chk(op_err == 0, "R8", "erase pass", op_err, 0);
    run_op(1, 13'h0123, 8'h00, 0, 40, 1, 0, 0);
    check_seq("R3");
    chk(op_err == 1, "R8", "erase fail bit", op_err, 1);

    // R4 zero length and clamp
    run_op(0, 13'h0777, 8'h10, 0, 10, 0, 0, 0);
    check_seq("R4");
    chk(widx == 0, "R4", "ack count zero len", widx, 0);
    run_op(0, 13'h0555, 8'hF0, 700, 20, 0, 0, 0);
    check_seq("R4");
    chk(widx == 528, "R4", "ack count clamped", widx, 528);
    run_op(0, 13'h0556, 8'h01, 528, 20, 0, 0, 0);
    chk(widx == 528, "R4", "ack count at max", widx, 528);

    // R10 start while busy ignored
    run_op(0, 13'h0100, 8'h22, 3, 200, 0, 0, 1);
    check_seq("R10");
    repeat (40) @(negedge clk);
    chk(ncap == nexp, "R10", "no extra writes after busy start", ncap, nexp);
    chk(busy_o == 0 && ce_no == 1, "R1", "idle after op", busy_o, 0);

    // R9 timeout
    run_op(1, 13'h0200, 8'h00, 0, 0, 0, 1, 0);
    chk(op_err == 1, "R9", "timeout error", op_err, 1);
    chk(op_done_cyc - conf_cyc >= E_TMO && op_done_cyc - conf_cyc <= E_TMO + 20,
        "R9", "timeout window", op_done_cyc - conf_cyc, E_TMO);
    hang = 0;

    // R11 random mix
    for (int k = 0; k < 8; k++) begin
      bit er, fl;
      int rw, cl, ln, bl;
      er = 1'($urandom); fl = 1'($urandom);
      rw = int'($urandom % 8192); cl = int'($urandom % 256);
      ln = int'($urandom % 40); bl = int'($urandom % 300);
      run_op(er, rw, cl, ln, bl, fl, 0, 0);
      check_seq("R11");
      check_timing();
      chk(op_err == int'(fl), "R8", "random result", op_err, int'(fl));
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule